// File: doc/BRIEF.md
# General-Purpose Input Interrupt Aggregator

This block watches a bank of general-purpose input pins and turns their activity into interrupt requests. Each pin first passes through a two-flop synchroniser. A pending event for each pin is recorded in a cause register. A per-pin enable register gates these events. The gated events are then OR-reduced into one summary request for each group of eight adjacent pins. These summary lines are meant to feed a downstream main interrupt controller.

One global mode bit chooses how every pin is detected. In edge mode, a rising edge latches the pin's cause bit, and software clears it by writing zero to that bit. In level mode, each cause bit tracks the synchronised pin level and cannot be cleared. Software reaches the control, enable, cause and pin-value registers through a simple synchronous register port. Read data is registered.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, the control, enable, cause and value registers all read 0 and every group summary output is 0.
- R2: Register map on `bus_addr`: 0 = control, 1 = enable, 2 = cause, 3 = value. `bus_rdata` shows the addressed register one cycle after the address is presented. Only control bit 10 is stored; the other control bits read 0.
- R3: With control bit 10 = 0 (edge mode), a rising edge on a pin sets that pin's cause bit within three clock edges. A falling edge sets nothing.
- R4: In edge mode, a write to the cause register clears every cause bit whose write-data bit is 0. Bits written with 1 keep their value.
- R5: In edge mode, when a clear and a new rising edge reach the same cause bit on the same clock edge, the bit ends up set.
- R6: With control bit 10 = 1 (level mode), each cause bit equals the synchronised pin level. Writes to the cause register have no effect.
- R7: Enable bit n gates pin n. A pending pin whose enable bit is 0 cannot drive any summary output.
- R8: Summary output g is 1 exactly when, on the previous clock edge, some pin in 8g..8g+7 had both its cause bit and its enable bit set.
- R9: The value register returns the synchronised pin levels. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 32 | Asynchronous general-purpose inputs |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| grp_irq_o | output | 4 | One summary request per group of eight pins |

## Verification
The bench builds the block with its default parameters: 32 pins in four groups of eight, and the mode bit at position 10. With these values, every summary output can be driven on its own and alongside the others. Masked and unmasked pins can be placed in the same group. The edge/level switch is reached through the real control bit position. The table walk is run in edge mode and builds up cause bits across steps. The directed tests cover the clear-versus-edge collision, level tracking with ignored writes, and the value register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_EN    = 2'd1,
    REG_CAUSE = 2'd2,
    REG_VALUE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, stab_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign level_o = stab_q;
  assign rise_o  = stab_q & ~prev_q;

  // A rise must be followed by the level staying visible as the new history
  p_rise_tracks_r3: assert property (@(posedge clk) disable iff (rst)
    (|rise_o) |=> ((prev_q & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         level_mode,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_keep,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    if (level_mode) begin
      cause_d = lvl_i;
    end else begin
      if (clr_en) cause_d = cause_d & clr_keep;
      cause_d = cause_d | rise_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  p_edge_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && (|rise_i)) |=> ((cause_q & $past(rise_i)) == $past(rise_i)));

  p_level_follows_r6: assert property (@(posedge clk) disable iff (rst)
    level_mode |=> (cause_q == $past(lvl_i)));

  p_keep_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && clr_en) |=>
      ((cause_q & $past(cause_q & clr_keep)) == $past(cause_q & clr_keep)));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int W     = 32,
  parameter int GSIZE = 8,
  localparam int NG   = W / GSIZE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  cause_i,
  input  logic [W-1:0]  en_i,
  output logic [NG-1:0] grp_o
);
  logic [W-1:0]  gated;
  logic [NG-1:0] grp_q;

  assign gated = cause_i & en_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) grp_q[g] <= 1'b0;
      else     grp_q[g] <= |gated[g*GSIZE +: GSIZE];
    end

    p_grp_needs_pending_r8: assert property (@(posedge clk) disable iff (rst)
      grp_q[g] |-> $past(|(cause_i[g*GSIZE +: GSIZE] & en_i[g*GSIZE +: GSIZE])));
  end

  assign grp_o = grp_q;
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int NUM_PINS  = 32,
  parameter int GROUP_SZ  = 8,
  parameter int MODE_BIT  = 10,
  localparam int NGROUPS  = NUM_PINS / GROUP_SZ
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  output logic [NGROUPS-1:0]  grp_irq_o
);
  import gpio_irq_pkg::*;

  logic                mode_q;
  logic [NUM_PINS-1:0] en_q, lvl, rise, cause, rdata_q;
  logic                clr_en;
  reg_sel_e            sel;

  assign sel    = reg_sel_e'(bus_addr);
  assign clr_en = bus_wr && (sel == REG_CAUSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      en_q   <= '0;
    end else if (bus_wr) begin
      if (sel == REG_CTRL) mode_q <= bus_wdata[MODE_BIT];
      if (sel == REG_EN)   en_q   <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (sel)
        REG_CTRL:  rdata_q <= NUM_PINS'(mode_q) << MODE_BIT;
        REG_EN:    rdata_q <= en_q;
        REG_CAUSE: rdata_q <= cause;
        default:   rdata_q <= lvl;
      endcase
    end
  end
  assign bus_rdata = rdata_q;

  gpio_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pins_i(pins_i), .level_o(lvl), .rise_o(rise)
  );

  gpio_irq_cause #(.W(NUM_PINS)) u_cause (
    .clk(clk), .rst(rst), .level_mode(mode_q), .lvl_i(lvl), .rise_i(rise),
    .clr_en(clr_en), .clr_keep(bus_wdata), .cause_o(cause)
  );

  gpio_irq_group #(.W(NUM_PINS), .GSIZE(GROUP_SZ)) u_grp (
    .clk(clk), .rst(rst), .cause_i(cause), .en_i(en_q), .grp_o(grp_irq_o)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (en_q == '0 && mode_q == 1'b0 && cause == '0 && grp_irq_o == '0));

  p_mode_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == REG_CTRL) |=> (mode_q == $past(bus_wdata[MODE_BIT])));

  p_en_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && sel == REG_EN) |=> $stable(en_q));
endmodule

// File: tb/sim_gpio_irq_agg.sv
module sim_gpio_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_agg u0 (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .grp_irq_o(grp)
  );

  typedef struct packed {
    logic [31:0] pins;
    logic [31:0] en;
    logic [31:0] keep;
    logic [31:0] cause;
    logic [3:0]  grp;
  } vec_t;

  // Edge mode, causes accumulate from step to step (R3, R4, R7, R8)
  localparam vec_t VEC [6] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0001},
    '{32'h0000_0101, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0101, 4'b0001},
    '{32'h8000_0101, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0101, 4'b1000},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h8000_0100, 4'b1010},
    '{32'h00FF_0000, 32'h0001_0000, 32'h7FFF_FFFF, 32'h00FF_0100, 4'b0100},
    '{32'h00FF_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 4'b0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 grp", {28'd0, grp}, 32'd0);
    bus_read(2'd0, rd); check("R1 ctrl", rd, 32'd0);
    bus_read(2'd1, rd); check("R1 enable", rd, 32'd0);
    bus_read(2'd2, rd); check("R1 cause", rd, 32'd0);
    bus_read(2'd3, rd); check("R1 value", rd, 32'd0);

    for (int v = 0; v < 6; v++) begin
      pins = VEC[v].pins;
      bus_write(2'd1, VEC[v].en);
      idle(4);
      bus_write(2'd2, VEC[v].keep);
      idle(2);
      bus_read(2'd2, rd);
      check($sformatf("R3/R4 cause step %0d", v), rd, VEC[v].cause);
      check($sformatf("R7/R8 grp step %0d", v), {28'd0, grp}, {28'd0, VEC[v].grp});
    end

    // R5: clear and new edge collide on pin 0
    @(negedge clk); pins = 32'h00FF_0001;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 2'd2; wdata = 32'd0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    bus_read(2'd2, rd); check("R5 edge beats clear", rd, 32'h0000_0001);
    bus_write(2'd2, 32'd0);

    // R2: control keeps only bit 10
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, rd); check("R2 ctrl readback", rd, 32'h0000_0400);

    // R6: level mode tracks pins and ignores writes
    pins = 32'h0000_0F00;
    bus_write(2'd1, 32'h0000_0100);
    idle(4);
    bus_read(2'd2, rd); check("R6 level cause", rd, 32'h0000_0F00);
    check("R8 level grp", {28'd0, grp}, 32'h2);
    bus_write(2'd2, 32'd0);
    bus_read(2'd2, rd); check("R6 write ignored", rd, 32'h0000_0F00);
    pins = 32'd0;
    idle(4);
    bus_read(2'd2, rd); check("R6 level drop", rd, 32'd0);
    check("R6 grp drop", {28'd0, grp}, 32'd0);

    // R9: value register mirrors pins, writes ignored
    pins = 32'hA5A5_0000;
    idle(3);
    bus_write(2'd3, 32'h1234_5678);
    bus_read(2'd3, rd); check("R9 value", rd, 32'hA5A5_0000);

    // R2: back to edge mode, falling edges must not set (R3)
    bus_write(2'd0, 32'd0);
    bus_read(2'd0, rd); check("R2 ctrl cleared", rd, 32'd0);
    bus_write(2'd2, 32'd0);
    pins = 32'd0;
    idle(4);
    bus_read(2'd2, rd); check("R3 fall no set", rd, 32'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule